// File: doc/BRIEF.md
# Three-Channel Edge Timestamp Capture

This block records the moment at which selected transitions occur on three external input pins. The time base is a free-running 16-bit counter that comes in as an input and is shared by all channels. Each pin passes through a two-stage synchronizer and then a stability filter. After that an edge detector fires on rising edges, falling edges, or both, as configured for that channel. When a qualifying edge arrives on an enabled channel, the current timer value goes into that channel's two-entry FIFO. The channel's interrupt flag is also raised.

Software sees a small register window. The control word holds each channel's enable, edge mode and interrupt mask. The status word gives how many entries each FIFO holds. The flag word holds the interrupt flags, which software clears by writing 1. Three data addresses return the oldest timestamp of each channel and pop it.

Top module: `tstamp_capture`

## Requirements
- R1: A pin level counts as a transition only after the synchronized level has been the same at two consecutive clock edges. If a pin takes a new level before clock edge k and holds it, the stored timestamp is the timer value at edge k+3. A level that is seen at a single edge only is ignored.
- R2: Channel i uses control bits [4i+3:4i]. Bit 4i is the enable. Bits [4i+2:4i+1] select the edge mode: 01 for rising, 10 for falling, 11 for both, 00 for none. Bit 4i+3 is the interrupt mask enable.
- R3: Each FIFO holds two 16-bit timestamps and is read oldest first. A capture into a full FIFO discards the oldest entry.
- R4: The status word (address 1) holds the fill level of channel i in bits [2i+1:2i]: 00 for empty, 01 for one entry, 10 for two. All other bits read 0.
- R5: A read of address 3+i returns the oldest entry of channel i and lowers its count by one. A read of an empty FIFO returns 0 and changes nothing. A pop and a capture in the same cycle leave the newest entries in order.
- R6: A channel whose enable bit is 0 ignores edges. A control write that clears a channel's enable bit also empties that channel's FIFO.
- R7: A capture sets flag bit i of the flag word (address 2). Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A capture in the same cycle as a clear leaves the flag set.
- R8: irq_o[i] is a register. It is 1 in the cycle after one in which flag i and mask i are both 1, and 0 otherwise.
- R9: A read returns its data on rdata_o one cycle after rd_en_i. rdata_o then holds that value until the next read. The control word reads back as written, and unmapped addresses (6, 7) read 0.
- R10: After reset, all registers, flags, FIFOs and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_i | input | 16 | Shared free-running time base |
| cap_pin_i | input | 3 | Asynchronous capture pins, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 3 | Per-channel interrupt lines |

## Verification
The bench goes after pulses that last one or two clock edges. A filter that is off by one stage would either capture glitches or miss real two-edge levels, and it would stamp every event with the wrong timer value. It drives three or more captures into a single FIFO without reads, reads FIFOs that are empty, and pops in the very cycle of a capture. A FIFO that drops the wrong end, wraps its count, or underflows would return stale or reordered stamps. It also clears flags in the cycle of a capture, where a design that gives the clear priority loses an interrupt. Finally, it disables a channel that holds entries and toggles its pin, where a design that lacks clear-on-disable or edge gating would report a nonzero fill level.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_t;

  localparam int unsigned CTRL_STRIDE = 4;
  localparam int unsigned ADR_CTRL    = 0;
  localparam int unsigned ADR_STAT    = 1;
  localparam int unsigned ADR_FLAG    = 2;
  localparam int unsigned ADR_DATA0   = 3;
endpackage

// File: rtl/ecap_inq.sv
module ecap_inq (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1, s2, s3, lvl;
  logic settle;

  // new level accepted once two consecutive samples agree
  assign settle = (s2 == s3) && (s3 != lvl);
  assign rise_o = settle && s3;
  assign fall_o = settle && !s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      s3  <= 1'b0;
      lvl <= 1'b0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      s3 <= s2;
      if (settle) lvl <= s3;
    end
  end
endmodule

// File: rtl/ecap_tsfifo.sv
module ecap_tsfifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             full, empty, do_pop, drop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign do_pop = pop && !empty;
  assign drop   = push && full && !do_pop;
  assign dout   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (do_pop || drop) rd_ptr <= nxt(rd_ptr);
      if (push && !do_pop && !full) count <= count + 1'b1;
      else if (!push && do_pop)     count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import ecap_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned TW    = 16,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [TW-1:0]  timer_i,
  input  logic [NCH-1:0] cap_pin_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]                ctrl_q;
  logic [NCH-1:0]               flag_q;
  logic [NCH-1:0]               en_w, mask_w, rise_w, fall_w, cap_w, pop_w, clr_w;
  logic [NCH-1:0][CNT_W-1:0]    cnt_w;
  logic [NCH-1:0][TW-1:0]       dout_w;
  logic                         ctrl_wr, flag_wr;
  logic [DW-1:0]                rd_val;

  assign ctrl_wr = wr_en_i && (addr_i == AW'(ADR_CTRL));
  assign flag_wr = wr_en_i && (addr_i == AW'(ADR_FLAG));

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      edge_sel_t m;
      m         = edge_sel_t'(ctrl_q[CTRL_STRIDE*i+1 +: 2]);
      en_w[i]   = ctrl_q[CTRL_STRIDE*i];
      mask_w[i] = ctrl_q[CTRL_STRIDE*i+3];
      cap_w[i]  = en_w[i] &&
                  ((rise_w[i] && (m == EDGE_RISE || m == EDGE_BOTH)) ||
                   (fall_w[i] && (m == EDGE_FALL || m == EDGE_BOTH)));
      pop_w[i]  = rd_en_i && (addr_i == AW'(ADR_DATA0 + i));
      clr_w[i]  = ctrl_wr && !wdata_i[CTRL_STRIDE*i];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ecap_inq u_inq (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (cap_pin_i[g]),
      .rise_o (rise_w[g]),
      .fall_o (fall_w[g])
    );
    ecap_tsfifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_w[g]),
      .push  (cap_w[g]),
      .din   (timer_i),
      .pop   (pop_w[g]),
      .dout  (dout_w[g]),
      .count (cnt_w[g])
    );
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == AW'(ADR_CTRL)) rd_val = ctrl_q;
    if (addr_i == AW'(ADR_STAT))
      for (int i = 0; i < NCH; i++) rd_val[i*CNT_W +: CNT_W] = cnt_w[i];
    if (addr_i == AW'(ADR_FLAG)) rd_val[NCH-1:0] = flag_q;
    for (int i = 0; i < NCH; i++)
      if (addr_i == AW'(ADR_DATA0 + i) && cnt_w[i] != '0)
        rd_val[TW-1:0] = dout_w[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      flag_q  <= '0;
      irq_o   <= '0;
      rdata_o <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata_i;
      flag_q  <= cap_w | (flag_q & ~({NCH{flag_wr}} & wdata_i[NCH-1:0]));
      irq_o   <= flag_q & mask_w;
      if (rd_en_i) rdata_o <= rd_val;
    end
  end
endmodule

// File: rtl/ecap_chk.sv
module ecap_chk #(
  parameter int unsigned NCH   = 3,
  parameter int unsigned CNT_W = 2,
  parameter int unsigned DEPTH = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0]            en,
  input logic [NCH-1:0]            mask,
  input logic [NCH-1:0]            cap,
  input logic [NCH-1:0]            pop,
  input logic [NCH-1:0]            flag,
  input logic [NCH-1:0]            irq,
  input logic [NCH-1:0][CNT_W-1:0] cnt
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
      cnt[i] <= CNT_W'(DEPTH));
    assert_off_empty_R6: assert property (@(posedge clk) disable iff (rst)
      !en[i] |=> cnt[i] == '0);
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
      cap[i] |=> flag[i]);
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> $past(flag[i] && mask[i]));
    assert_pop_dec_R5: assert property (@(posedge clk) disable iff (rst)
      (pop[i] && cnt[i] != '0 && !cap[i] && en[i]) |=> cnt[i] == $past(cnt[i]) - 1'b1);
  end
endmodule

bind tstamp_capture ecap_chk #(.NCH(NCH), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .en   (en_w),
  .mask (mask_w),
  .cap  (cap_w),
  .pop  (pop_w),
  .flag (flag_q),
  .irq  (irq_o),
  .cnt  (cnt_w)
);

// File: tb/sim_tstamp_capture.sv
module sim_tstamp_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tmr = 16'h1230;
  logic [2:0]  pin = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  irq;

  tstamp_capture u0 (
    .clk(clk), .rst(rst), .timer_i(tmr), .cap_pin_i(pin),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  string tag = "R10";

  // behavioural reference
  int          fq [3][$];
  logic [15:0] ctrl_m = '0;
  logic [2:0]  flags_m = '0, irq_e = '0;
  logic [15:0] rdata_e = '0;
  logic [2:0]  p1 = '0, p2 = '0, p3 = '0, lvl = '0;

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    logic [15:0] rv;
    if (rd_en) begin
      rv = '0;
      case (addr)
        3'd0: rv = ctrl_m;
        3'd1: for (int i = 0; i < 3; i++) rv[2*i +: 2] = 2'(fq[i].size());
        3'd2: rv = {13'd0, flags_m};
        3'd3, 3'd4, 3'd5:
          if (fq[addr-3].size() > 0) rv = 16'(fq[addr-3][0]);
        default: rv = '0;
      endcase
      rdata_e = rv;
    end
    for (int i = 0; i < 3; i++) irq_e[i] = flags_m[i] & ctrl_m[4*i+3];
    for (int i = 0; i < 3; i++) begin
      bit r = 0, f = 0, c;
      if (p2[i] == p3[i] && p2[i] != lvl[i]) begin
        lvl[i] = p2[i]; r = p2[i]; f = !p2[i];
      end
      c = ctrl_m[4*i] && ((r && ctrl_m[4*i+1]) || (f && ctrl_m[4*i+2]));
      if (rd_en && addr == 3'(3 + i) && fq[i].size() > 0) void'(fq[i].pop_front());
      if (c) begin
        fq[i].push_back(int'(tmr));
        if (fq[i].size() > 2) void'(fq[i].pop_front());
      end
      if (wr_en && addr == 3'd2 && wdata[i]) flags_m[i] = 1'b0;
      if (c) flags_m[i] = 1'b1;
    end
    p3 = p2; p2 = p1; p1 = pin;
    if (wr_en && addr == 3'd0) begin
      ctrl_m = wdata;
      for (int i = 0; i < 3; i++) if (!wdata[4*i]) fq[i].delete();
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    step();
    @(negedge clk);
    check("rdata", 32'(rdata), 32'(rdata_e));
    check("irq", 32'(irq), 32'(irq_e));
    tmr = tmr + 16'd7;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic bus_wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a);
    rd_en = 1'b1; addr = a;
    cyc();
    rd_en = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) begin
      bus_rd(3'(3 + i)); bus_rd(3'(3 + i));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tag = "watchdog";
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tag = "R10";
    check("rdata after reset", 32'(rdata), 0);
    check("irq after reset", 32'(irq), 0);
    bus_rd(3'd0); bus_rd(3'd1); bus_rd(3'd2); bus_rd(3'd3);

    // R2: ch0 rising, ch1 falling, ch2 both, all masked in
    tag = "R2";
    bus_wr(3'd0, 16'h0FDB);
    bus_rd(3'd0);
    pin = 3'b111; idle(6);
    bus_rd(3'd1); bus_rd(3'd2);
    pin = 3'b000; idle(6);
    bus_rd(3'd1);
    tag = "R1";
    bus_rd(3'd3); bus_rd(3'd4); bus_rd(3'd5); bus_rd(3'd5);

    // R1: one-edge glitch ignored, two-edge pulse taken
    pin[2] = 1'b1; cyc(); pin[2] = 1'b0; idle(6);
    bus_rd(3'd1);
    pin[2] = 1'b1; idle(2); pin[2] = 1'b0; idle(6);
    bus_rd(3'd1); bus_rd(3'd5); bus_rd(3'd5); bus_rd(3'd5);
    drain();

    // R3: overflow drops oldest
    tag = "R3";
    for (int k = 0; k < 3; k++) begin
      pin[0] = 1'b1; idle(5); pin[0] = 1'b0; idle(5);
    end
    bus_rd(3'd1);
    tag = "R5";
    bus_rd(3'd3); bus_rd(3'd1); bus_rd(3'd3); bus_rd(3'd3); bus_rd(3'd1);

    // R7: clear, and clear racing a capture
    tag = "R7";
    bus_wr(3'd2, 16'h0007); bus_rd(3'd2);
    pin[0] = 1'b1;
    for (int k = 0; k < 6; k++) bus_wr(3'd2, 16'h0001);
    bus_rd(3'd2); idle(2);
    bus_wr(3'd2, 16'h0000); bus_rd(3'd2);
    pin[0] = 1'b0; drain();

    // R8: mask off ch1
    tag = "R8";
    bus_wr(3'd2, 16'h0007);
    bus_wr(3'd0, 16'h0F5B);
    pin[1] = 1'b1; idle(5); pin[1] = 1'b0; idle(6);
    bus_rd(3'd2); idle(2);

    // R6: disable ch2 holding entries
    tag = "R6";
    pin[2] = 1'b1; idle(5); pin[2] = 1'b0; idle(5);
    bus_rd(3'd1);
    bus_wr(3'd0, 16'h005B);
    bus_rd(3'd1);
    pin[2] = 1'b1; idle(5); pin[2] = 1'b0; idle(5);
    bus_rd(3'd1); bus_rd(3'd5);
    tag = "R9";
    bus_rd(3'd6); bus_rd(3'd7); idle(3);
    bus_wr(3'd0, 16'hFFDB); bus_rd(3'd0);

    // R4: mixed random traffic with pops racing captures
    tag = "R4";
    bus_wr(3'd0, 16'h0FDB);
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < 3; i++)
        if ($urandom_range(0, 3) == 0) pin[i] = ~pin[i];
      case ($urandom_range(0, 9))
        0, 1: begin rd_en = 1'b1; addr = 3'($urandom_range(3, 5)); end
        2:    begin rd_en = 1'b1; addr = 3'd1; end
        3:    begin wr_en = 1'b1; addr = 3'd2; wdata = 16'($urandom_range(0, 7)); end
        4:    if ($urandom_range(0, 20) == 0) begin
                wr_en = 1'b1; addr = 3'd0; wdata = 16'($urandom_range(0, 4095));
              end
        default: ;
      endcase
      cyc();
      rd_en = 1'b0; wr_en = 1'b0;
    end
    tag = "R5";
    drain(); bus_rd(3'd1);
    finish_run();
  end
endmodule